// File: doc/BRIEF.md
# Mailbox Command Block Sequencer

This block sits on the coprocessor side of a one-word host mailbox. The host writes 16-bit words one after another. The sequencer splits that stream into command blocks. Each block opens with a command word whose flag bits say which operations the block requests. Every flag brings a fixed number of parameter words with it. The sequencer adds up those counts, collects that many following words into a parameter array, and then offers the decoded block on a valid/ready output.

A downstream executor accepts the block with the ready signal. The sequencer stalls the mailbox until that happens. When the executor accepts the block, the sequencer raises a one-cycle interrupt request if the block asked for a completion interrupt. It raises a one-cycle end-of-sequence pulse if the block carried the last-command flag. A command word with any undefined bit set is dropped with an error pulse, and the sequencer goes back to waiting for a command word. Executing the commands is left to the consumer.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset, `word_rdy` is 1 and `blk_valid`, `err_pulse`, `irq_req` and `seq_end` are 0.
- R2: The flag bits of a command word are at these positions: bit 5 last command, bit 7 shared-memory address, bit 9 begin execution, bit 11 completion interrupt, bit 13 dump, bit 15 load. Any mix of these bits may be set. They appear on `blk_cmd` as bit 0 last, 1 address, 2 begin, 3 completion interrupt, 4 dump, 5 load.
- R3: Each flag adds a fixed number of parameter words: last 0, address 2, begin 2, completion interrupt 1, dump 5, load 5. `blk_count` is the sum of these counts for the flags that are set.
- R4: A command word of 0x0000 is a generic I/O command. It has 5 parameter words, `blk_generic` is 1 and `blk_cmd` is 0.
- R5: Parameter words land in `blk_param` in arrival order. Word k is at bits [16k+15:16k]. The arrival order groups the words by ascending flag-bit position. Slots at index `blk_count` or above read as zero.
- R6: `blk_valid` rises one cycle after the last parameter word is taken. For a block with no parameter words, it rises one cycle after the command word is taken.
- R7: While `blk_valid` is 1 and `blk_ready` is 0, `blk_cmd`, `blk_count` and `blk_param` hold steady and `word_rdy` is 0, so no word is consumed.
- R8: A command word that has any bit set other than 5, 7, 9, 11, 13, 15 produces a one-cycle `err_pulse` in the next cycle. It produces no block, and the next word is treated as a command word.
- R9: One cycle after a block with the completion-interrupt flag is accepted, `irq_req` pulses for one cycle. It never pulses otherwise.
- R10: One cycle after a block with the last-command flag is accepted, `seq_end` pulses for one cycle. It never pulses otherwise.
- R11: In the cycle after a block is accepted, `blk_valid` is 0 and `word_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_vld | input | 1 | Mailbox holds a word |
| word_data | input | 16 | Mailbox word |
| word_rdy | output | 1 | The word is consumed on this edge when `word_vld` is 1 |
| blk_valid | output | 1 | A decoded block is on offer |
| blk_ready | input | 1 | Consumer accepts the block |
| blk_cmd | output | 6 | Decoded flags of the block |
| blk_generic | output | 1 | Block is a generic I/O command |
| blk_count | output | 4 | Number of parameter words in the block |
| blk_param | output | 240 | Parameter array, word k at bits [16k+15:16k] |
| err_pulse | output | 1 | Rejected command word |
| irq_req | output | 1 | Completion interrupt request |
| seq_end | output | 1 | The command sequence has ended |

## Verification
The hardest case to reach is a held block while the mailbox already offers the next word. That is where a missed stall would swallow a word or corrupt the parameter array. The driver therefore sends words back to back, sometimes with random gaps. Meanwhile the monitor delays `blk_ready` by a random zero to three cycles, so command words and parameter words often arrive while a block is still waiting. Boundary blocks are also covered. These include one with no parameter words (last flag alone), one with every flag for the full fifteen words followed by a short block that must clear the stale slots, and rejected words placed between valid blocks.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

   localparam int NFLAG = 6;

   // flag index order on the decoded vector, lowest word bit first
   localparam int FI_LAST  = 0;
   localparam int FI_ADDR  = 1;
   localparam int FI_BEGIN = 2;
   localparam int FI_CBI   = 3;
   localparam int FI_DUMP  = 4;
   localparam int FI_LOAD  = 5;

   typedef logic [NFLAG-1:0] flag_vec_t;

   typedef enum logic [1:0] {
      ST_WAIT_CMD = 2'd0,
      ST_GATHER   = 2'd1,
      ST_PRESENT  = 2'd2
   } seq_state_e;

   // command word bit that carries flag i
   function automatic int flag_bit(input int i);
      return 5 + 2 * i;
   endfunction

   // true when bit b of a command word is a defined flag
   function automatic bit is_flag_bit(input int b);
      return (b >= 5) && (b <= 15) && ((b % 2) == 1);
   endfunction

endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
   import mbx_seq_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int CNT_W     = 4,
   parameter int P_LAST    = 0,
   parameter int P_ADDR    = 2,
   parameter int P_BEGIN   = 2,
   parameter int P_CBI     = 1,
   parameter int P_DUMP    = 5,
   parameter int P_LOAD    = 5,
   parameter int P_GENERIC = 5
) (
   input  logic [WORD_W-1:0] word,
   output flag_vec_t         flags,
   output logic              generic,
   output logic              bad,
   output logic [CNT_W-1:0]  total
);

   localparam int CNT_TAB [NFLAG] = '{P_LAST, P_ADDR, P_BEGIN, P_CBI, P_DUMP, P_LOAD};

   logic [CNT_W-1:0]  part [NFLAG];
   logic [WORD_W-1:0] known;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      localparam int FB = flag_bit(i);
      assign flags[i] = word[FB];
      assign part[i]  = word[FB] ? CNT_W'(CNT_TAB[i]) : '0;
   end

   for (genvar b = 0; b < WORD_W; b++) begin : g_mask
      assign known[b] = is_flag_bit(b);
   end

   assign bad     = |(word & ~known);
   assign generic = (flags == '0);

   always_comb begin
      total = '0;
      for (int i = 0; i < NFLAG; i++) begin
         total = total + part[i];
      end
      if (generic) begin
         total = CNT_W'(P_GENERIC);
      end
   end

endmodule

// File: rtl/mbx_param_buf.sv
module mbx_param_buf #(
   parameter int WORD_W       = 16,
   parameter int DEPTH        = 15,
   parameter int IDX_W        = 4,
   parameter bit CLEAR_UNUSED = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    we,
   input  logic [IDX_W-1:0]        widx,
   input  logic [WORD_W-1:0]       wdata,
   output logic [DEPTH*WORD_W-1:0] flat
);

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      logic [WORD_W-1:0] slot_q;
      logic              hit;

      assign hit = we && (widx == IDX_W'(k));

      if (CLEAR_UNUSED) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= wdata;
            else if (clr) slot_q <= '0;
         end
      end else begin : g_keep
         logic unused_clr;
         assign unused_clr = clr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= wdata;
         end
      end

      assign flat[k*WORD_W +: WORD_W] = slot_q;
   end

endmodule

// File: rtl/mbx_out_stage.sv
module mbx_out_stage
   import mbx_seq_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  flag_vec_t        ld_flags,
   input  logic             ld_generic,
   input  logic [CNT_W-1:0] ld_count,
   input  logic             ready,
   output logic             valid,
   output flag_vec_t        flags,
   output logic             generic,
   output logic [CNT_W-1:0] count,
   output logic             irq,
   output logic             done
);

   logic accept;
   assign accept = valid && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         flags   <= '0;
         generic <= 1'b0;
         count   <= '0;
         irq     <= 1'b0;
         done    <= 1'b0;
      end else begin
         irq  <= accept && flags[FI_CBI];
         done <= accept && flags[FI_LAST];
         if (load) begin
            valid   <= 1'b1;
            flags   <= ld_flags;
            generic <= ld_generic;
            count   <= ld_count;
         end else if (accept) begin
            valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
   import mbx_seq_pkg::*;
#(
   parameter int  WORD_W       = 16,
   parameter int  P_LAST       = 0,
   parameter int  P_ADDR       = 2,
   parameter int  P_BEGIN      = 2,
   parameter int  P_CBI        = 1,
   parameter int  P_DUMP       = 5,
   parameter int  P_LOAD       = 5,
   parameter int  P_GENERIC    = 5,
   parameter bit  CLEAR_UNUSED = 1'b1,
   localparam int P_SUM   = P_LAST + P_ADDR + P_BEGIN + P_CBI + P_DUMP + P_LOAD,
   localparam int MAX_P   = (P_SUM > P_GENERIC) ? P_SUM : P_GENERIC,
   localparam int IDX_W   = $clog2(MAX_P + 1),
   localparam int PARAM_W = MAX_P * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_vld,
   input  logic [WORD_W-1:0]  word_data,
   output logic               word_rdy,
   output logic               blk_valid,
   input  logic               blk_ready,
   output logic [NFLAG-1:0]   blk_cmd,
   output logic               blk_generic,
   output logic [IDX_W-1:0]   blk_count,
   output logic [PARAM_W-1:0] blk_param,
   output logic               err_pulse,
   output logic               irq_req,
   output logic               seq_end
);

   if (WORD_W < 16) begin : g_chk_width
      $error("mbx_cmd_seq: WORD_W must cover the flag bits");
   end
   if (P_LAST < 0 || P_ADDR < 0 || P_BEGIN < 0 || P_CBI < 0 ||
       P_DUMP < 0 || P_LOAD < 0 || P_GENERIC < 0) begin : g_chk_neg
      $error("mbx_cmd_seq: parameter word counts must not be negative");
   end
   if (MAX_P < 1 || MAX_P > 64) begin : g_chk_depth
      $error("mbx_cmd_seq: parameter array depth out of range");
   end

   seq_state_e       state_q;
   flag_vec_t        cur_flags_q;
   logic             cur_generic_q;
   logic [IDX_W-1:0] cur_total_q;
   logic [IDX_W-1:0] fill_q;
   logic             err_q;

   flag_vec_t        dec_flags;
   logic             dec_generic;
   logic             dec_bad;
   logic [IDX_W-1:0] dec_total;

   logic take, cmd_ok, cmd_bad, buf_we, last_param, out_load;
   flag_vec_t        ld_flags;
   logic             ld_generic;
   logic [IDX_W-1:0] ld_count;

   mbx_cmd_decode #(
      .WORD_W(WORD_W), .CNT_W(IDX_W),
      .P_LAST(P_LAST), .P_ADDR(P_ADDR), .P_BEGIN(P_BEGIN), .P_CBI(P_CBI),
      .P_DUMP(P_DUMP), .P_LOAD(P_LOAD), .P_GENERIC(P_GENERIC)
   ) u_decode (
      .word    (word_data),
      .flags   (dec_flags),
      .generic (dec_generic),
      .bad     (dec_bad),
      .total   (dec_total)
   );

   assign word_rdy   = (state_q != ST_PRESENT);
   assign take       = word_vld && word_rdy;
   assign cmd_ok     = take && (state_q == ST_WAIT_CMD) && !dec_bad;
   assign cmd_bad    = take && (state_q == ST_WAIT_CMD) && dec_bad;
   assign buf_we     = take && (state_q == ST_GATHER);
   assign last_param = buf_we && ((fill_q + 1'b1) == cur_total_q);
   assign out_load   = (cmd_ok && (dec_total == '0)) || last_param;

   assign ld_flags   = (state_q == ST_WAIT_CMD) ? dec_flags   : cur_flags_q;
   assign ld_generic = (state_q == ST_WAIT_CMD) ? dec_generic : cur_generic_q;
   assign ld_count   = (state_q == ST_WAIT_CMD) ? dec_total   : cur_total_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_WAIT_CMD;
         cur_flags_q   <= '0;
         cur_generic_q <= 1'b0;
         cur_total_q   <= '0;
         fill_q        <= '0;
         err_q         <= 1'b0;
      end else begin
         err_q <= cmd_bad;
         unique case (state_q)
            ST_WAIT_CMD: begin
               if (cmd_ok) begin
                  cur_flags_q   <= dec_flags;
                  cur_generic_q <= dec_generic;
                  cur_total_q   <= dec_total;
                  fill_q        <= '0;
                  state_q       <= (dec_total == '0) ? ST_PRESENT : ST_GATHER;
               end
            end
            ST_GATHER: begin
               if (buf_we) begin
                  fill_q <= fill_q + 1'b1;
                  if (last_param) state_q <= ST_PRESENT;
               end
            end
            ST_PRESENT: begin
               if (blk_valid && blk_ready) state_q <= ST_WAIT_CMD;
            end
            default: state_q <= ST_WAIT_CMD;
         endcase
      end
   end

   mbx_param_buf #(
      .WORD_W(WORD_W), .DEPTH(MAX_P), .IDX_W(IDX_W), .CLEAR_UNUSED(CLEAR_UNUSED)
   ) u_params (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cmd_ok),
      .we    (buf_we),
      .widx  (fill_q),
      .wdata (word_data),
      .flat  (blk_param)
   );

   mbx_out_stage #(
      .CNT_W(IDX_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (out_load),
      .ld_flags   (ld_flags),
      .ld_generic (ld_generic),
      .ld_count   (ld_count),
      .ready      (blk_ready),
      .valid      (blk_valid),
      .flags      (blk_cmd),
      .generic    (blk_generic),
      .count      (blk_count),
      .irq        (irq_req),
      .done       (seq_end)
   );

   assign err_pulse = err_q;

endmodule

// File: rtl/mbx_cmd_seq_chk.sv
module mbx_cmd_seq_chk #(
   parameter int PW    = 240,
   parameter int CNT_W = 4,
   parameter int MAXP  = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             word_vld,
   input logic             word_rdy,
   input logic             blk_valid,
   input logic             blk_ready,
   input logic [5:0]       blk_cmd,
   input logic [CNT_W-1:0] blk_count,
   input logic [PW-1:0]    blk_param,
   input logic             err_pulse,
   input logic             irq_req,
   input logic             seq_end
);

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |-> (int'(blk_count) <= MAXP));

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_param) &&
                                     $stable(blk_cmd) && $stable(blk_count)));

   assert_no_take_when_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |-> !word_rdy);

   assert_err_follows_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ($past(word_vld && word_rdy) && !blk_valid));

   assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(blk_valid && blk_ready && blk_cmd[3]));

   assert_irq_given_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && blk_ready && blk_cmd[3]) |=> irq_req);

   assert_end_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end |-> $past(blk_valid && blk_ready && blk_cmd[0]));

   assert_end_given_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && blk_ready && blk_cmd[0]) |=> seq_end);

   assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && blk_ready) |=> (!blk_valid && word_rdy));

endmodule

bind mbx_cmd_seq mbx_cmd_seq_chk #(
   .PW(PARAM_W), .CNT_W(IDX_W), .MAXP(MAX_P)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .word_vld  (word_vld),
   .word_rdy  (word_rdy),
   .blk_valid (blk_valid),
   .blk_ready (blk_ready),
   .blk_cmd   (blk_cmd),
   .blk_count (blk_count),
   .blk_param (blk_param),
   .err_pulse (err_pulse),
   .irq_req   (irq_req),
   .seq_end   (seq_end)
);

// File: tb/mbx_cmd_seq_bench.sv
module mbx_cmd_seq_bench;

   localparam int MAXP = 15;
   localparam int PW   = MAXP * 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          word_vld = 1'b0;
   logic [15:0]   word_data = '0;
   logic          word_rdy;
   logic          blk_valid;
   logic          blk_ready = 1'b0;
   logic [5:0]    blk_cmd;
   logic          blk_generic;
   logic [3:0]    blk_count;
   logic [PW-1:0] blk_param;
   logic          err_pulse;
   logic          irq_req;
   logic          seq_end;

   int checks = 0;
   int errors = 0;
   int spur   = 0;

   typedef struct {
      logic [5:0]    fl;
      logic          gen;
      int            cnt;
      logic [PW-1:0] pv;
   } exp_t;

   exp_t q[$];

   always #10 clk = ~clk;

   mbx_cmd_seq u_mbx_cmd_seq (
      .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_data(word_data),
      .word_rdy(word_rdy), .blk_valid(blk_valid), .blk_ready(blk_ready),
      .blk_cmd(blk_cmd), .blk_generic(blk_generic), .blk_count(blk_count),
      .blk_param(blk_param), .err_pulse(err_pulse), .irq_req(irq_req),
      .seq_end(seq_end)
   );

   task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act,
                      input logic [PW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-flag counts, R3 order: last, addr, begin, cbi, dump, load
   function automatic int flag_cnt(input int i);
      case (i)
         0: return 0;
         1: return 2;
         2: return 2;
         3: return 1;
         default: return 5;
      endcase
   endfunction

   task automatic send(input logic [15:0] w, input int gap);
      word_vld = 1'b0;
      repeat (gap) @(negedge clk);
      word_vld  = 1'b1;
      word_data = w;
      while (!word_rdy) @(negedge clk);
      @(negedge clk);
      word_vld = 1'b0;
   endtask

   // driver: build expected block, push it, then feed the words
   task automatic send_block(input logic [5:0] fl, input bit gaps);
      exp_t e;
      logic [15:0] w;
      w = '0;
      e.fl = fl;
      e.gen = (fl == 6'd0);
      e.cnt = 0;
      e.pv = '0;
      for (int i = 0; i < 6; i++) begin
         if (fl[i]) begin
            w[5 + 2*i] = 1'b1;
            e.cnt += flag_cnt(i);
         end
      end
      if (e.gen) e.cnt = 5;
      for (int k = 0; k < e.cnt; k++) e.pv[k*16 +: 16] = 16'($urandom);
      q.push_back(e);
      send(w, gaps ? int'($urandom_range(0, 2)) : 0);
      for (int k = 0; k < e.cnt; k++)
         send(e.pv[k*16 +: 16], gaps ? int'($urandom_range(0, 2)) : 0);
   endtask

   task automatic send_bad(input logic [15:0] w);
      send(w, 0);
      chk(err_pulse === 1'b1, "R8 err pulse", PW'(err_pulse), PW'(1));
      chk(blk_valid === 1'b0, "R8 no block", PW'(blk_valid), PW'(0));
   endtask

   // monitor: pops expected blocks and compares what the design offers
   bit   pend = 1'b0;
   exp_t cur;
   initial begin
      bit have;
      int stall;
      have = 1'b0;
      stall = 0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (pend) begin
            blk_ready = 1'b0;
            pend = 1'b0;
            chk(blk_valid === 1'b0 && word_rdy === 1'b1, "R11 release",
                PW'({blk_valid, word_rdy}), PW'(2'b01));
            chk(irq_req === cur.fl[3], "R9 irq", PW'(irq_req), PW'(cur.fl[3]));
            chk(seq_end === cur.fl[0], "R10 seq end", PW'(seq_end), PW'(cur.fl[0]));
         end else if (blk_valid) begin
            if (!have) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R6 unexpected block", PW'(blk_cmd), PW'(0));
                  cur.fl = blk_cmd; cur.gen = blk_generic;
                  cur.cnt = int'(blk_count); cur.pv = blk_param;
               end else begin
                  cur = q.pop_front();
               end
               have = 1'b1;
               stall = int'($urandom_range(0, 3));
            end
            chk(blk_cmd === cur.fl, "R2 flags", PW'(blk_cmd), PW'(cur.fl));
            chk(blk_generic === cur.gen, "R4 generic", PW'(blk_generic), PW'(cur.gen));
            chk(int'(blk_count) == cur.cnt, "R3 count", PW'(blk_count), PW'(cur.cnt));
            chk(blk_param === cur.pv, "R5 params", blk_param, cur.pv);
            chk(word_rdy === 1'b0, "R7 stall", PW'(word_rdy), PW'(0));
            if (irq_req || seq_end) spur++;
            if (stall == 0) begin
               blk_ready = 1'b1;
               pend = 1'b1;
               have = 1'b0;
            end else begin
               stall--;
            end
         end else begin
            if (irq_req || seq_end) spur++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(word_rdy === 1'b1 && blk_valid === 1'b0, "R1 reset handshake",
          PW'({word_rdy, blk_valid}), PW'(2'b10));
      chk(err_pulse === 1'b0 && irq_req === 1'b0 && seq_end === 1'b0,
          "R1 reset pulses", PW'({err_pulse, irq_req, seq_end}), PW'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R6 block with no parameter words, offered one cycle after the command
      q.push_back('{fl: 6'b000001, gen: 1'b0, cnt: 0, pv: '0});
      send(16'h0020, 0);
      chk(blk_valid === 1'b1, "R6 zero-param valid", PW'(blk_valid), PW'(1));
      wait (q.size() == 0 && !blk_valid && !pend);
      @(negedge clk);

      // R6 valid one cycle after final parameter word
      q.push_back('{fl: 6'b000010, gen: 1'b0, cnt: 2, pv: PW'(32'hBEEF_1234)});
      send(16'h0080, 0);
      send(16'h1234, 1);
      chk(blk_valid === 1'b0, "R6 not early", PW'(blk_valid), PW'(0));
      send(16'hBEEF, 0);
      chk(blk_valid === 1'b1, "R6 valid after last word", PW'(blk_valid), PW'(1));

      send_block(6'b001100, 1'b0); // begin + cbi: 3 words
      send_block(6'b110000, 1'b0); // dump + load: 10 words
      send_block(6'b111111, 1'b0); // all flags: 15 words
      send_block(6'b000010, 1'b0); // R5 stale slots must be cleared
      send_block(6'b000000, 1'b1); // R4 generic
      send_bad(16'h0001);          // R8
      send_bad(16'h1000);
      send_bad(16'h8001);
      send_block(6'b001000, 1'b0); // R8 back to waiting for a command
      send_bad(16'h0040);
      send_block(6'b101001, 1'b1);
      for (int n = 0; n < 40; n++) begin
         send_block(6'($urandom_range(0, 63)), 1'($urandom));
      end
      send_block(6'b000001, 1'b0);

      wait (q.size() == 0 && !blk_valid && !pend);
      repeat (4) @(negedge clk);
      chk(spur == 0, "R9 R10 no stray pulses", PW'(spur), PW'(0));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule